// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small fully associative cache of recent virtual-page-to-physical-frame translations. Each resident translation carries the identifier of the address space (process) that owns it, so translations from several processes can live in the buffer at once. A lookup presents a virtual page number and the current address-space identifier; one cycle later the block returns a hit flag, the frame number and the permission bits. After a miss, the page walker (outside this block) writes the translation back through the fill port.

Invalidation is available for the whole buffer or for the entries of a single address space. A mode input turns identifier tagging off; in that mode identifiers play no part in matching and every context switch empties the buffer. Changing the mode also empties it, so entries made under one matching rule never meet the other. Replacement prefers a free slot and otherwise rotates through the entries.

Top module: `asid_tlb`

## Requirements
- R1: A lookup strobed in cycle N answers in cycle N+1 with rsp_valid_o high; on a hit lk_hit_o is 1 and lk_pfn_o/lk_perm_o carry the stored frame and permissions, on a miss all three are 0.
- R2: With tagging on, an entry whose identifier differs from lk_asid_i never hits, even when its page number matches.
- R3: After reset every entry is invalid and no lookup hits; an invalid entry never hits.
- R4: A fill that does not match a resident entry writes the lowest-index invalid entry; with no entry free it writes the entry at the rotation pointer (0 after reset), which then advances by one modulo the entry count.
- R5: flush_all_i invalidates every entry from the next cycle.
- R6: flush_asid_i invalidates exactly the entries whose identifier equals flush_asid_val_i; all others stay valid.
- R7: With tagging off, matching ignores identifiers and ctx_switch_i invalidates every entry; with tagging on, ctx_switch_i has no effect.
- R8: A change of tag_en_i invalidates every entry; a lookup in the cycle of the change still uses the old contents and mode, and the new mode applies from the next cycle.
- R9: A lookup in the same cycle as a fill request for the same page (and identifier, when tagging is on) reports a miss; the filled translation hits from the next cycle.
- R10: A fill request in a cycle with any invalidation (full, by identifier, context switch or mode change) is dropped.
- R11: A fill matching a resident entry overwrites that entry, so at most one entry ever matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tag_en_i | input | 1 | 1: match on identifier too; 0: identifiers ignored |
| ctx_switch_i | input | 1 | Context switch strobe |
| lk_req_i | input | 1 | Lookup strobe |
| lk_vpn_i | input | 20 | Lookup virtual page number |
| lk_asid_i | input | 8 | Current address-space identifier |
| rsp_valid_o | output | 1 | Lookup answer valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pfn_o | output | 20 | Frame number on hit |
| lk_perm_o | output | 3 | Permission bits on hit |
| fill_i | input | 1 | Fill strobe |
| fill_vpn_i | input | 20 | Fill page number |
| fill_asid_i | input | 8 | Fill identifier |
| fill_pfn_i | input | 20 | Fill frame number |
| fill_perm_i | input | 3 | Fill permission bits |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_asid_i | input | 1 | Invalidate entries of one identifier |
| flush_asid_val_i | input | 8 | Identifier to invalidate |

## Verification
Assertions check every cycle that no two entries match one lookup, that full and per-identifier invalidations leave no targeted entry valid, that the rotation pointer moves only on a rotating fill, that answers follow requests by one cycle and that a same-page fill collision yields a miss. Only the bench scenarios can show the returned frame values, the choice of victim under the free-slot and rotation rules, the identifier filtering in both modes and the dropping of fills during invalidation, which it compares against a reference model through a scoreboard.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    VSRC_HIT  = 2'd0,
    VSRC_FREE = 2'd1,
    VSRC_RR   = 2'd2
  } vsrc_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PERM_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tag_en_i,
  input  logic [VPN_W-1:0]             lk_vpn_i,
  input  logic [ASID_W-1:0]            lk_asid_i,
  input  logic [VPN_W-1:0]             fill_vpn_i,
  input  logic [ASID_W-1:0]            fill_asid_i,
  input  logic [PFN_W-1:0]             fill_pfn_i,
  input  logic [PERM_W-1:0]            fill_perm_i,
  input  logic                         wr_en_i,
  input  logic [N-1:0]                 wr_sel_i,
  input  logic                         clr_all_i,
  input  logic                         clr_asid_i,
  input  logic [ASID_W-1:0]            clr_asid_val_i,
  output logic [N-1:0]                 lk_match_o,
  output logic [N-1:0]                 fill_match_o,
  output logic [N-1:0]                 valid_o,
  output logic [N-1:0][PFN_W-1:0]      pfn_o,
  output logic [N-1:0][PERM_W-1:0]     perm_o
);
  logic [N-1:0]             valid_q;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][ASID_W-1:0] asid_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        vpn_q[i]   <= '0;
        asid_q[i]  <= '0;
        pfn_o[i]   <= '0;
        perm_o[i]  <= '0;
      end else if (clr_all_i) begin
        valid_q[i] <= 1'b0;
      end else if (clr_asid_i && asid_q[i] == clr_asid_val_i) begin
        valid_q[i] <= 1'b0;
      end else if (wr_en_i && wr_sel_i[i]) begin
        valid_q[i] <= 1'b1;
        vpn_q[i]   <= fill_vpn_i;
        asid_q[i]  <= fill_asid_i;
        pfn_o[i]   <= fill_pfn_i;
        perm_o[i]  <= fill_perm_i;
      end
    end

    assign lk_match_o[i]   = valid_q[i] && vpn_q[i] == lk_vpn_i &&
                             (!tag_en_i || asid_q[i] == lk_asid_i);
    assign fill_match_o[i] = valid_q[i] && vpn_q[i] == fill_vpn_i &&
                             (!tag_en_i || asid_q[i] == fill_asid_i);

    // R6
    asid_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_asid_i && valid_q[i] && asid_q[i] == clr_asid_val_i) |=> !valid_q[i]);
  end

  assign valid_o = valid_q;

  // R11
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match_o));

  // R5
  flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> (valid_q == '0));
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fill_do_i,
  input  logic [N-1:0] valid_i,
  input  logic [N-1:0] fill_match_i,
  output logic [N-1:0] sel_o,
  output vsrc_e        src_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] ptr_q;
  logic [N-1:0]     free_oh;
  logic             any_free;

  always_comb begin
    free_oh  = '0;
    any_free = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!valid_i[i] && !any_free) begin
        free_oh[i] = 1'b1;
        any_free   = 1'b1;
      end
    end
  end

  always_comb begin
    if (|fill_match_i) begin
      sel_o = fill_match_i;
      src_o = VSRC_HIT;
    end else if (any_free) begin
      sel_o = free_oh;
      src_o = VSRC_FREE;
    end else begin
      sel_o = '0;
      sel_o[ptr_q] = 1'b1;
      src_o = VSRC_RR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (fill_do_i && src_o == VSRC_RR)
      ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R4
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_do_i && src_o == VSRC_RR) |=> $stable(ptr_q));
  // R4
  rr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_do_i |-> $onehot(sel_o));
endmodule

// File: rtl/tlb_out_reg.sv
module tlb_out_reg #(
  parameter int N      = 16,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lk_req_i,
  input  logic [N-1:0]             hit_vec_i,
  input  logic [N-1:0][PFN_W-1:0]  pfn_i,
  input  logic [N-1:0][PERM_W-1:0] perm_i,
  output logic                     rsp_valid_o,
  output logic                     lk_hit_o,
  output logic [PFN_W-1:0]         lk_pfn_o,
  output logic [PERM_W-1:0]        lk_perm_o
);
  logic [PFN_W-1:0]  pfn_mux;
  logic [PERM_W-1:0] perm_mux;

  // one-hot AND-OR mux; zero when no entry hits
  always_comb begin
    pfn_mux  = '0;
    perm_mux = '0;
    for (int i = 0; i < N; i++) begin
      pfn_mux  |= pfn_i[i]  & {PFN_W{hit_vec_i[i]}};
      perm_mux |= perm_i[i] & {PERM_W{hit_vec_i[i]}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      lk_hit_o    <= 1'b0;
      lk_pfn_o    <= '0;
      lk_perm_o   <= '0;
    end else begin
      rsp_valid_o <= lk_req_i;
      lk_hit_o    <= lk_req_i && (|hit_vec_i);
      lk_pfn_o    <= lk_req_i ? pfn_mux  : '0;
      lk_perm_o   <= lk_req_i ? perm_mux : '0;
    end
  end

  // R1
  rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> rsp_valid_o);
  // R1
  hit_needs_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> rsp_valid_o);
  // R1
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !lk_hit_o) |-> (lk_pfn_o == '0 && lk_perm_o == '0));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PERM_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tag_en_i,
  input  logic              ctx_switch_i,
  input  logic              lk_req_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              rsp_valid_o,
  output logic              lk_hit_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  output logic [PERM_W-1:0] lk_perm_o,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [PERM_W-1:0] fill_perm_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_val_i
);
  logic                     tag_q;
  logic                     mode_chg, clr_all, any_flush, fill_do, collide;
  logic [N-1:0]             lk_match, fill_match, valid, wr_sel, hit_vec;
  logic [N-1:0][PFN_W-1:0]  pfn_arr;
  logic [N-1:0][PERM_W-1:0] perm_arr;
  vsrc_e                    vsrc;

  // mode takes effect one cycle late, together with the flush it causes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tag_q <= 1'b1;
    else         tag_q <= tag_en_i;
  end

  assign mode_chg  = tag_en_i != tag_q;
  assign clr_all   = flush_all_i || mode_chg || (ctx_switch_i && !tag_q);
  assign any_flush = clr_all || flush_asid_i;
  assign fill_do   = fill_i && !any_flush;
  assign collide   = fill_i && lk_req_i && fill_vpn_i == lk_vpn_i &&
                     (!tag_q || fill_asid_i == lk_asid_i);
  assign hit_vec   = collide ? '0 : lk_match;

  tlb_entry_array #(
    .N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .PERM_W(PERM_W)
  ) u_array (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tag_en_i       (tag_q),
    .lk_vpn_i       (lk_vpn_i),
    .lk_asid_i      (lk_asid_i),
    .fill_vpn_i     (fill_vpn_i),
    .fill_asid_i    (fill_asid_i),
    .fill_pfn_i     (fill_pfn_i),
    .fill_perm_i    (fill_perm_i),
    .wr_en_i        (fill_do),
    .wr_sel_i       (wr_sel),
    .clr_all_i      (clr_all),
    .clr_asid_i     (flush_asid_i),
    .clr_asid_val_i (flush_asid_val_i),
    .lk_match_o     (lk_match),
    .fill_match_o   (fill_match),
    .valid_o        (valid),
    .pfn_o          (pfn_arr),
    .perm_o         (perm_arr)
  );

  tlb_victim_sel #(.N(N)) u_victim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_do_i    (fill_do),
    .valid_i      (valid),
    .fill_match_i (fill_match),
    .sel_o        (wr_sel),
    .src_o        (vsrc)
  );

  tlb_out_reg #(.N(N), .PFN_W(PFN_W), .PERM_W(PERM_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_req_i    (lk_req_i),
    .hit_vec_i   (hit_vec),
    .pfn_i       (pfn_arr),
    .perm_i      (perm_arr),
    .rsp_valid_o (rsp_valid_o),
    .lk_hit_o    (lk_hit_o),
    .lk_pfn_o    (lk_pfn_o),
    .lk_perm_o   (lk_perm_o)
  );

  // R9
  collide_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide |=> !lk_hit_o);
  // R10
  fill_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && any_flush) |=> $stable(pfn_arr));
  // R8
  mode_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (valid == '0));
  // R7
  ctx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_switch_i && !tag_q) |=> (valid == '0));
endmodule

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        d_tag = 1'b1, d_ctx = 1'b0, d_req = 1'b0, d_fill = 1'b0;
  logic        d_fa = 1'b0, d_fx = 1'b0;
  logic [19:0] d_vpn = '0, d_fvpn = '0, d_fpfn = '0;
  logic [7:0]  d_asid = '0, d_fasid = '0, d_fxval = '0;
  logic [2:0]  d_fperm = '0;

  logic        rsp_valid, hit;
  logic [19:0] pfn;
  logic [2:0]  perm;

  asid_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tag_en_i(d_tag), .ctx_switch_i(d_ctx),
    .lk_req_i(d_req), .lk_vpn_i(d_vpn), .lk_asid_i(d_asid),
    .rsp_valid_o(rsp_valid), .lk_hit_o(hit), .lk_pfn_o(pfn), .lk_perm_o(perm),
    .fill_i(d_fill), .fill_vpn_i(d_fvpn), .fill_asid_i(d_fasid),
    .fill_pfn_i(d_fpfn), .fill_perm_i(d_fperm),
    .flush_all_i(d_fa), .flush_asid_i(d_fx), .flush_asid_val_i(d_fxval)
  );

  typedef struct {
    logic        hit;
    logic [19:0] pfn;
    logic [2:0]  perm;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "";

  // reference model
  logic        m_v[N];
  logic [19:0] m_vpn[N], m_pfn[N];
  logic [7:0]  m_asid[N];
  logic [2:0]  m_perm[N];
  int          m_ptr = 0;
  logic        m_tag = 1'b1;

  function automatic bit m_match(int i, logic [19:0] vpn, logic [7:0] asid);
    return m_v[i] && m_vpn[i] == vpn && (!m_tag || m_asid[i] == asid);
  endfunction

  task automatic step();
    exp_t e;
    bit mchg, clr, anyf, found;
    int vic;
    if (d_req) begin
      e.hit = 0; e.pfn = '0; e.perm = '0; e.req = cur_req;
      if (!(d_fill && d_fvpn == d_vpn && (!m_tag || d_fasid == d_asid)))
        for (int i = 0; i < N; i++)
          if (m_match(i, d_vpn, d_asid)) begin
            e.hit = 1; e.pfn = m_pfn[i]; e.perm = m_perm[i];
          end
      exp_q.push_back(e);
    end
    mchg = d_tag != m_tag;
    clr  = d_fa || mchg || (d_ctx && !m_tag);
    anyf = clr || d_fx;
    if (d_fill && !anyf) begin
      found = 0; vic = 0;
      for (int i = 0; i < N; i++)
        if (!found && m_match(i, d_fvpn, d_fasid)) begin found = 1; vic = i; end
      for (int i = 0; i < N; i++)
        if (!found && !m_v[i]) begin found = 1; vic = i; end
      if (!found) begin vic = m_ptr; m_ptr = (m_ptr + 1) % N; end
      m_v[vic] = 1; m_vpn[vic] = d_fvpn; m_asid[vic] = d_fasid;
      m_pfn[vic] = d_fpfn; m_perm[vic] = d_fperm;
    end
    for (int i = 0; i < N; i++)
      if (clr || (d_fx && m_asid[i] == d_fxval)) m_v[i] = 0;
    m_tag = d_tag;
    @(posedge clk);
    @(negedge clk);
    d_req = 0; d_fill = 0; d_fa = 0; d_fx = 0; d_ctx = 0;
  endtask

  task automatic set_lookup(logic [19:0] vpn, logic [7:0] asid);
    d_req = 1; d_vpn = vpn; d_asid = asid;
  endtask

  task automatic set_fill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] f, logic [2:0] p);
    d_fill = 1; d_fvpn = vpn; d_fasid = asid; d_fpfn = f; d_fperm = p;
  endtask

  task automatic lookup(string r, logic [19:0] vpn, logic [7:0] asid);
    cur_req = r; set_lookup(vpn, asid); step();
  endtask

  task automatic fill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] f, logic [2:0] p);
    set_fill(vpn, asid, f, p); step();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R1 unexpected response: hit=%0b expected none", hit);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (hit !== e.hit || pfn !== e.pfn || perm !== e.perm) begin
          n_fail++;
          $display("FAIL %s hit/pfn/perm actual %0b/%h/%0d expected %0b/%h/%0d",
                   e.req, hit, pfn, perm, e.hit, e.pfn, e.perm);
        end
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    n_chk++;
    if (rsp_valid !== 1'b0 || hit !== 1'b0) begin
      n_fail++;
      $display("FAIL R3 reset outputs actual %0b/%0b expected 0/0", rsp_valid, hit);
    end
    lookup("R3", 20'h00100, 8'd1);

    fill(20'h00100, 8'd1, 20'hAAA01, 3'd5);
    fill(20'h00200, 8'd1, 20'hAAA02, 3'd3);
    fill(20'h00300, 8'd2, 20'hAAA03, 3'd1);
    lookup("R1", 20'h00100, 8'd1);
    lookup("R1", 20'h00200, 8'd1);
    lookup("R1", 20'h00300, 8'd2);
    lookup("R2", 20'h00300, 8'd1);
    lookup("R2", 20'h00100, 8'd2);

    // R9 same-cycle fill and lookup
    cur_req = "R9"; set_fill(20'h00400, 8'd1, 20'hAAA04, 3'd7);
    set_lookup(20'h00400, 8'd1); step();
    lookup("R9", 20'h00400, 8'd1);

    // R11 refill of resident page overwrites
    fill(20'h00100, 8'd1, 20'hBBB01, 3'd2);
    lookup("R11", 20'h00100, 8'd1);

    // R4 fill to capacity then rotate
    for (int k = 0; k < 12; k++) fill(20'h01000 + 20'(k), 8'd3, 20'hC0000 + 20'(k), 3'd4);
    lookup("R4", 20'h01005, 8'd3);
    fill(20'h02000, 8'd3, 20'hD0000, 3'd6);
    lookup("R4", 20'h00100, 8'd1);
    lookup("R4", 20'h02000, 8'd3);
    fill(20'h02001, 8'd3, 20'hD0001, 3'd6);
    lookup("R4", 20'h00200, 8'd1);
    lookup("R4", 20'h00300, 8'd2);

    // R6 flush one identifier
    d_fx = 1; d_fxval = 8'd3; step();
    lookup("R6", 20'h01005, 8'd3);
    lookup("R6", 20'h02001, 8'd3);
    lookup("R6", 20'h00300, 8'd2);
    lookup("R6", 20'h00400, 8'd1);
    fill(20'h00500, 8'd1, 20'hE0005, 3'd1);
    lookup("R4", 20'h00500, 8'd1);

    // R10 fill dropped during invalidation
    d_fx = 1; d_fxval = 8'd2; set_fill(20'h00600, 8'd2, 20'hE0006, 3'd2); step();
    lookup("R10", 20'h00600, 8'd2);
    lookup("R6", 20'h00300, 8'd2);
    d_fa = 1; set_fill(20'h00700, 8'd4, 20'hE0007, 3'd2); step();
    lookup("R10", 20'h00700, 8'd4);
    fill(20'h00400, 8'd1, 20'hAAA04, 3'd7);

    // R7 context switch ignored with tagging on
    d_ctx = 1; step();
    lookup("R7", 20'h00400, 8'd1);

    // R8 mode change: same-cycle lookup uses old contents
    d_tag = 0; cur_req = "R8"; set_lookup(20'h00400, 8'd1); step();
    lookup("R8", 20'h00400, 8'd1);

    // R7 tagging off: identifiers ignored, context switch flushes
    fill(20'h00700, 8'd5, 20'hF0007, 3'd3);
    lookup("R7", 20'h00700, 8'd9);
    d_ctx = 1; step();
    lookup("R7", 20'h00700, 8'd5);

    // R5 flush all
    d_tag = 1; step();
    fill(20'h00800, 8'd1, 20'hF0008, 3'd5);
    lookup("R5", 20'h00800, 8'd1);
    d_fa = 1; step();
    lookup("R5", 20'h00800, 8'd1);

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 missing responses actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule